// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Buffered Compare and Gated Converter Trigger

This block is one channel of a center-aligned PWM timer. A counter climbs from zero to a programmed period and then falls back to zero. The two turning points of that triangle are the peak, where the count reaches the period, and the valley, where it returns to zero. The PWM output is high while the count is at or above a compare value, called the cycle value. Software does not write the cycle value directly while the timer runs. It writes a shadow buffer, and a two-bit mode picks the turning points at which the shadow is copied into the live cycle value. Because the copy lands at a turning point, a half-period never mixes the old and new values.

Each selected turning-point event (peak or valley) drives an interrupt pulse and an analog-converter start pulse. A skip counter can thin these events so that only every N-th one raises the interrupt. A link bit ties the converter start pulse to the same thinning. When the link is set and skipping is inactive, no converter start is issued at all. Software reaches the block through a small register bus with byte lanes. The control register accepts only full-width writes.

Top module: `tripwm_timer`

## Requirements
- R1: With control bit 0 (run) set and period P nonzero, the count rises by one per clock from zero. In the clock after a cycle where the count is at or above P while rising, it starts falling by one. In the clock after it reads zero while falling, it starts rising again. With run clear or P equal to zero, the count holds its value.
- R2: `crest` is high exactly in the clocks where the counter is running, rising, P is nonzero and count >= P. `trough` is high exactly in the clocks where it is running, falling, P is nonzero and count is zero. The two are never high together.
- R3: With control bits [2:1] (transfer mode) equal to 00, the cycle value is never loaded from the buffer. It changes only through direct writes to address 2.
- R4: Transfer mode 01 loads the buffer into the cycle value at each crest clock, 10 at each trough clock, and 11 at both. The new value is seen from the following clock on. A direct write to address 2 in the same clock takes priority.
- R5: After reset the count, direction (rising), period, buffer, cycle value, skip count and every control field are zero, including transfer mode 00.
- R6: `pwm_out` is high exactly when run is set and the count is at or above the cycle value.
- R7: The selected event is crest when control bit 4 is 0 and trough when it is 1. When control bit 3 (skip enable) is set and the skip count N at address 3 is nonzero, `irq` pulses only on every N-th selected event. The internal tally then restarts from zero.
- R8: When skipping is inactive (bit 3 clear or N equal to zero), `irq` pulses on every selected event.
- R9: With control bit 5 (link) clear, `ad_start` pulses on every selected event, whatever the skip setting.
- R10: With link set and skipping inactive, `ad_start` never pulses.
- R11: With link set and skipping active, `ad_start` pulses exactly when `irq` does.
- R12: A write to the control register (address 4) with `bus_be` other than 2'b11 leaves it unchanged. Its fields are bits [5:0] as listed above, and the upper bits read as zero.
- R13: Addresses 0 (period), 1 (buffer), 2 (cycle value) and 3 (skip count) are written per byte lane and read back on `bus_rdata` in the same clock the address is presented. Unused upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte lane enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| count | output | CNT_W | Current counter value |
| crest | output | 1 | Peak turning-point flag |
| trough | output | 1 | Valley turning-point flag |
| pwm_out | output | 1 | Compare output |
| irq | output | 1 | Skip-gated event interrupt pulse |
| ad_start | output | 1 | Converter start pulse |

## Verification
A direction bit stuck at the wrong value shows within one clock. The count then steps past the period or wraps below zero, and the turning flags appear on the wrong clocks. A bad load of the cycle value shows on `pwm_out` within half a period. A skip tally that is off by one moves the `irq` and `ad_start` pulses to another event inside N selected events. Because every port is compared on every clock, each such fault is reported in the first clock where it differs.

// File: rtl/tripwm_pkg.sv
package tripwm_pkg;

  localparam int BUS_W  = 16;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 6;

  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_BUFFER = 3'd1;
  localparam logic [ADDR_W-1:0] A_CYCLE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SKIP   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  typedef enum logic [1:0] {
    XFER_NONE   = 2'b00,
    XFER_CREST  = 2'b01,
    XFER_TROUGH = 2'b10,
    XFER_BOTH   = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic       link;
    logic       src_trough;
    logic       skip_en;
    xfer_mode_e xfer;
    logic       run;
  } ctrl_t;

  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [1:0]       be);
    return {be[1] ? new_v[15:8] : old_v[15:8],
            be[0] ? new_v[7:0]  : old_v[7:0]};
  endfunction

  function automatic logic xfer_hit(input xfer_mode_e m,
                                    input logic       at_crest,
                                    input logic       at_trough);
    return (m[0] & at_crest) | (m[1] & at_trough);
  endfunction

endpackage

// File: rtl/tri_counter.sv
module tri_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             crest,
  output logic             trough
);

  logic rising;
  logic live;

  assign live   = run && (period != '0);
  assign crest  = live && rising && (count >= period);
  assign trough = live && !rising && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rising <= 1'b1;
    end else if (live) begin
      if (rising) begin
        if (count >= period) begin
          rising <= 1'b0;
          count  <= count - 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else begin
        if (count == '0) begin
          rising <= 1'b1;
          count  <= count + 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  // R2
  turn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(crest && trough));

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == $past(count));

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !crest && !trough) |=>
      ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)));

endmodule

// File: rtl/cycle_store.sv
module cycle_store
  import tripwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_mode_e       mode,
  input  logic             crest,
  input  logic             trough,
  input  logic [CNT_W-1:0] buf_val,
  input  logic             host_wr,
  input  logic [CNT_W-1:0] host_val,
  output logic [CNT_W-1:0] cyc
);

  logic load_now;

  assign load_now = xfer_hit(mode, crest, trough);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
    end else if (host_wr) begin
      cyc <= host_val;
    end else if (load_now) begin
      cyc <= buf_val;
    end
  end

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !host_wr) |=> cyc == $past(buf_val));

  // R3
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XFER_NONE && !host_wr) |=> $stable(cyc));

endmodule

// File: rtl/skip_gate.sv
module skip_gate #(
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crest,
  input  logic              trough,
  input  logic              src_trough,
  input  logic              skip_en,
  input  logic [SKIP_W-1:0] skip_n,
  input  logic              link,
  output logic              irq,
  output logic              ad_start
);

  logic [SKIP_W-1:0] tally;
  logic              sel_ev;
  logic              active;
  logic              fire;

  assign sel_ev = src_trough ? trough : crest;
  assign active = skip_en && (skip_n != '0);
  assign fire   = active && sel_ev &&
                  (({1'b0, tally} + 1'b1) >= {1'b0, skip_n});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally <= '0;
    end else if (!active) begin
      tally <= '0;
    end else if (sel_ev) begin
      tally <= fire ? '0 : tally + 1'b1;
    end
  end

  assign irq      = active ? fire : sel_ev;
  assign ad_start = link ? fire : sel_ev;

  // R10
  link_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link && !active) |-> !ad_start);

  // R11
  link_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link && ad_start) |-> irq);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sel_ev);

endmodule

// File: rtl/tripwm_timer.sv
module tripwm_timer
  import tripwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [CNT_W-1:0]  count,
  output logic              crest,
  output logic              trough,
  output logic              pwm_out,
  output logic              irq,
  output logic              ad_start
);

  logic [CNT_W-1:0]  per_q;
  logic [CNT_W-1:0]  buf_q;
  logic [SKIP_W-1:0] skn_q;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cyc;
  logic              cyc_wr;
  logic [CNT_W-1:0]  cyc_wval;
  logic              ctrl_full;

  assign ctrl_full = (bus_be == 2'b11);
  assign cyc_wr    = bus_wr && (bus_addr == A_CYCLE) && (bus_be != 2'b00);
  assign cyc_wval  = CNT_W'(lane_merge(BUS_W'(cyc), bus_wdata, bus_be));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      buf_q  <= '0;
      skn_q  <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_PERIOD: per_q <= CNT_W'(lane_merge(BUS_W'(per_q), bus_wdata, bus_be));
        A_BUFFER: buf_q <= CNT_W'(lane_merge(BUS_W'(buf_q), bus_wdata, bus_be));
        A_SKIP:   skn_q <= SKIP_W'(lane_merge(BUS_W'(skn_q), bus_wdata, bus_be));
        A_CTRL:   if (ctrl_full) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_PERIOD: bus_rdata = BUS_W'(per_q);
      A_BUFFER: bus_rdata = BUS_W'(buf_q);
      A_CYCLE:  bus_rdata = BUS_W'(cyc);
      A_SKIP:   bus_rdata = BUS_W'(skn_q);
      A_CTRL:   bus_rdata = BUS_W'(ctrl_q);
      default:  bus_rdata = '0;
    endcase
  end

  tri_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q.run),
    .period (per_q),
    .count  (count),
    .crest  (crest),
    .trough (trough)
  );

  cycle_store #(.CNT_W(CNT_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (ctrl_q.xfer),
    .crest    (crest),
    .trough   (trough),
    .buf_val  (buf_q),
    .host_wr  (cyc_wr),
    .host_val (cyc_wval),
    .cyc      (cyc)
  );

  skip_gate #(.SKIP_W(SKIP_W)) u_skip (
    .clk        (clk),
    .rst_n      (rst_n),
    .crest      (crest),
    .trough     (trough),
    .src_trough (ctrl_q.src_trough),
    .skip_en    (ctrl_q.skip_en),
    .skip_n     (skn_q),
    .link       (ctrl_q.link),
    .irq        (irq),
    .ad_start   (ad_start)
  );

  assign pwm_out = ctrl_q.run && (count >= cyc);

  // R12
  ctrl_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_be != 2'b11) |=> ctrl_q == $past(ctrl_q));

  // R6
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !pwm_out);

endmodule

// File: tb/test_tripwm_timer.sv
module test_tripwm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_be = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [CW-1:0] count;
  logic          crest, trough, pwm_out, irq, ad_start;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side model state
  logic [15:0] m_cnt = '0;
  logic        m_up = 1'b1;
  logic [15:0] m_per = '0, m_buf = '0, m_cyc = '0;
  logic [3:0]  m_skn = '0, m_sc = '0;
  logic [5:0]  m_ctrl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tripwm_timer #(.CNT_W(CW), .SKIP_W(SW)) i_tripwm_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .crest(crest), .trough(trough), .pwm_out(pwm_out),
    .irq(irq), .ad_start(ad_start)
  );

  function automatic logic e_run();  return m_ctrl[0]; endfunction
  function automatic logic [1:0] e_mode(); return m_ctrl[2:1]; endfunction
  function automatic logic e_live(); return m_ctrl[0] && m_per != 0; endfunction
  function automatic logic e_crest(); return e_live() && m_up && m_cnt >= m_per; endfunction
  function automatic logic e_trough(); return e_live() && !m_up && m_cnt == 0; endfunction
  function automatic logic e_ev(); return m_ctrl[4] ? e_trough() : e_crest(); endfunction
  function automatic logic e_act(); return m_ctrl[3] && m_skn != 0; endfunction
  function automatic logic e_fire();
    return e_act() && e_ev() && (int'(m_sc) + 1 >= int'(m_skn));
  endfunction
  function automatic logic e_irq(); return e_act() ? e_fire() : e_ev(); endfunction
  function automatic logic e_ad(); return m_ctrl[5] ? e_fire() : e_ev(); endfunction
  function automatic logic [15:0] e_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_per;
      3'd1: return m_buf;
      3'd2: return m_cyc;
      3'd3: return {12'd0, m_skn};
      3'd4: return {10'd0, m_ctrl};
      default: return 16'd0;
    endcase
  endfunction
  function automatic logic [15:0] lanes(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] be);
    return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string rq;
    chk(count == m_cnt, "R1 count", count, m_cnt);
    chk(crest == e_crest(), "R2 crest", 16'(crest), 16'(e_crest()));
    chk(trough == e_trough(), "R2 trough", 16'(trough), 16'(e_trough()));
    chk(pwm_out == (e_run() && m_cnt >= m_cyc), "R6 pwm", 16'(pwm_out),
        16'(e_run() && m_cnt >= m_cyc));
    chk(irq == e_irq(), e_act() ? "R7 irq" : "R8 irq", 16'(irq), 16'(e_irq()));
    rq = !m_ctrl[5] ? "R9 ad_start" : (e_act() ? "R11 ad_start" : "R10 ad_start");
    chk(ad_start == e_ad(), rq, 16'(ad_start), 16'(e_ad()));
    if (bus_addr == 3'd2) rq = (e_mode() == 2'b00) ? "R3 cycle" : "R4 cycle";
    else if (bus_addr == 3'd4) rq = "R12 ctrl";
    else rq = "R13 rdata";
    chk(bus_rdata == e_rd(bus_addr), rq, bus_rdata, e_rd(bus_addr));
  endtask

  task automatic model_step(input bit wr, input logic [2:0] a, input logic [1:0] be,
                            input logic [15:0] d);
    logic       cr, tr, ev, fi, act, hw;
    logic [1:0] md;
    cr = e_crest(); tr = e_trough(); ev = e_ev(); fi = e_fire(); act = e_act();
    md = e_mode();
    hw = wr && a == 3'd2 && be != 2'b00;
    // cycle value: host write first, then transfer per mode
    if (hw) m_cyc = lanes(m_cyc, d, be);
    else if ((md[0] && cr) || (md[1] && tr)) m_cyc = m_buf;
    // skip tally
    if (!act) m_sc = 0;
    else if (ev) m_sc = fi ? 4'd0 : m_sc + 1'b1;
    // counter
    if (e_live()) begin
      if (m_up) begin
        if (m_cnt >= m_per) begin m_up = 1'b0; m_cnt = m_cnt - 1'b1; end
        else m_cnt = m_cnt + 1'b1;
      end else begin
        if (m_cnt == 0) begin m_up = 1'b1; m_cnt = m_cnt + 1'b1; end
        else m_cnt = m_cnt - 1'b1;
      end
    end
    // registers
    if (wr) begin
      case (a)
        3'd0: m_per = lanes(m_per, d, be);
        3'd1: m_buf = lanes(m_buf, d, be);
        3'd3: m_skn = lanes({12'd0, m_skn}, d, be) & 16'hF;
        3'd4: if (be == 2'b11) m_ctrl = d[5:0];
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input bit wr, input logic [2:0] a, input logic [1:0] be,
                     input logic [15:0] d);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    #1;
    compare_all();
    model_step(wr, a, be, d);
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, a, 2'b11, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      logic [2:0] a;
      a = 3'($urandom % 5);
      if ($urandom % 6 == 0) cyc(1'b1, 3'd1, 2'b11, 16'($urandom % 16));
      else cyc(1'b0, a, 2'b00, 16'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R5 reset state
    bus_addr = 3'd4; #1;
    chk(bus_rdata == 16'h0 && count == 0, "R5 reset ctrl/count", bus_rdata, 16'h0);
    bus_addr = 3'd2; #1;
    chk(bus_rdata == 16'h0, "R5 reset cycle", bus_rdata, 16'h0);

    // R5: buffer loaded and counter running with default transfer mode: no load
    wr16(3'd0, 16'd4);
    wr16(3'd1, 16'd3);
    wr16(3'd4, 16'h0001);
    for (int i = 0; i < 20; i++) cyc(1'b0, 3'd2, 2'b00, 16'h0);
    chk(bus_rdata == 16'h0, "R5 no transfer after reset", bus_rdata, 16'h0);

    // R12: byte writes to control ignored
    cyc(1'b1, 3'd4, 2'b01, 16'h003E);
    cyc(1'b0, 3'd4, 2'b00, 16'h0);
    chk(bus_rdata == 16'h0001, "R12 low-byte write ignored", bus_rdata, 16'h0001);
    cyc(1'b1, 3'd4, 2'b10, 16'hFF3E);
    cyc(1'b0, 3'd4, 2'b00, 16'h0);
    chk(bus_rdata == 16'h0001, "R12 high-byte write ignored", bus_rdata, 16'h0001);

    // R13: per-lane write on period
    cyc(1'b1, 3'd0, 2'b10, 16'hAB00);
    cyc(1'b0, 3'd0, 2'b00, 16'h0);
    chk(bus_rdata == 16'hAB04, "R13 lane write", bus_rdata, 16'hAB04);
    wr16(3'd4, 16'h0000);
    wr16(3'd0, 16'd4);

    // R1: period zero freezes count
    wr16(3'd4, 16'h0000);
    wr16(3'd0, 16'd0);
    wr16(3'd4, 16'h0001);
    idle(8);

    // sweep of modes, skip counts and link
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 3; k++) begin
        for (int lk = 0; lk < 2; lk++) begin
          logic [3:0]  skn;
          logic [15:0] per, c;
          logic        sen, src;
          skn = (k == 0) ? 4'd0 : (k == 1 ? 4'd1 : 4'd3);
          sen = (md == 3 && lk == 1 && k == 2) ? 1'b0 : 1'b1;
          src = 1'($urandom % 2);
          per = 16'(2 + $urandom % 9);
          wr16(3'd4, 16'h0000);
          wr16(3'd0, per);
          wr16(3'd1, 16'($urandom % (per + 2)));
          wr16(3'd2, 16'($urandom % (per + 2)));
          wr16(3'd3, {12'd0, skn});
          c = {10'd0, 1'(lk), src, sen, 2'(md), 1'b1};
          wr16(3'd4, c);
          idle(120);
          if ($urandom % 2 == 0) cyc(1'b1, 3'd4, 2'b01, 16'h0000);
          idle(20);
        end
      end
    end

    // R4: direct cycle write colliding with a crest transfer
    wr16(3'd4, 16'h0000);
    wr16(3'd0, 16'd3);
    wr16(3'd1, 16'd1);
    wr16(3'd4, 16'h0007);
    for (int i = 0; i < 40; i++) begin
      if (e_crest()) cyc(1'b1, 3'd2, 2'b11, 16'd2);
      else cyc(1'b0, 3'd2, 2'b00, 16'h0);
    end

    // stopped counter holds
    wr16(3'd4, 16'h0000);
    idle(10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule